// File: doc/BRIEF.md
# Counter-Based Random Word Engine

This block serves a stream of 32-bit pseudo-random words. It keeps a 64-bit key and a 128-bit counter. The upper half of the counter selects a subsequence and the lower half is the block position within it. An instantiated bijection core turns the counter and the key into a 128-bit block. The engine buffers that block as four words and hands them out one per valid/ready transfer. A new block is computed only once the four buffered words are used up and a consumer asks for more. The counter then advances by one.

Software-style control uses plain pins. A one-cycle seed load installs a new key and subsequence and discards anything buffered or in flight. A one-cycle skip pulse moves the block position forward by any 64-bit amount, and the carry runs into the subsequence half.

The output side follows these back-pressure rules:
- A word transfers on a clock edge where `out_valid` and `out_ready` are both high.
- While `out_ready` is low, the offered word and `out_valid` hold steady.
- The consumer may hold `out_ready` high at any time. An empty buffer with `out_ready` high is the request that starts a refill.

Top module: `crng_stream`

## Requirements
- R1: After a seed load, the key's low 32 bits (key word 0) equal `seed_val[31:0]` and its high 32 bits (key word 1) equal `seed_val[63:32]`.
- R2: After a seed load, counter words 0 and 1 (bits 63:0) are zero, counter word 2 (bits 95:64) equals `subseq_val[31:0]`, and counter word 3 (bits 127:96) equals `subseq_val[63:32]`.
- R3: A seed load takes priority over every other input. It empties the buffer, returns the word index to 0 and abandons any refill in progress. The next word delivered is word 0 of the block for the new key and counter.
- R4: Out of reset, the key is parameter `DEFAULT_SEED` (default 67280421310721), the subsequence is `DEFAULT_SUBSEQ` (default 0), and `out_valid` is low.
- R5: A refill starts when the buffer is empty and `out_ready` is high. It applies the bijection to the current counter and key, and the counter grows by exactly one per refill.
- R6: The words of a block are delivered word 0 (bits 31:0) first, up to word 3 (bits 127:96), one per valid/ready transfer. The index wraps modulo 4 and the buffer empties after word 3.
- R7: The one-step increment carries across all four counter words, so the all-ones counter wraps to zero.
- R8: A skip of n adds n to counter bits 63:0. A carry out of bit 63 adds one to bits 127:64, which wrap at 2^64. A skip issued mid-block changes only the blocks that follow.
- R9: A skip pulse during a refill is ignored. An accepted skip completes in one cycle and delays a refill request made in the same cycle, so the new block uses the skipped counter.
- R10: `out_valid` stays low while a refill is pending. While `out_valid` is high and `out_ready` low, `out_word` and `out_valid` hold.
- R11: The bijection runs `ROUNDS` rounds. Round i uses key (k0 + i*0x9E3779B9, k1 + i*0xBB67AE85), each sum taken mod 2^32. A round maps counter words (c0, c1, c2, c3) to the following, where hiA:loA = 0xD2511F53*c0 and hiB:loB = 0xCD9E8D57*c2 are 64-bit products:
  - word 0 = hiB ^ c1 ^ k0
  - word 1 = loB
  - word 2 = hiA ^ c3 ^ k1
  - word 3 = loA

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | One-cycle pulse: install `seed_val` and `subseq_val` |
| seed_val | input | 64 | Seed that becomes the key |
| subseq_val | input | 64 | Subsequence for counter bits 127:64 |
| skip_en | input | 1 | One-cycle pulse: advance the block position by `skip_count` |
| skip_count | input | 64 | Number of 128-bit blocks to skip |
| out_valid | output | 1 | A buffered word is offered |
| out_ready | input | 1 | Consumer accepts / requests words |
| out_word | output | 32 | Offered random word |

## Verification
The bench builds the engine with its default parameters. These are a ten-round bijection, the stated default seed and subsequence zero. With ten rounds the refill window is long enough to land skip pulses and value checks in the middle of a refill. The reset state is checked against the default key. Seeds and subsequences loaded through the port reach the corners: a counter that wraps through all 128 bits, and a skip whose carry crosses into the subsequence half.

// File: rtl/crng_pkg.sv
package crng_pkg;
  typedef logic [31:0]  word_t;
  typedef logic [63:0]  key_t;
  typedef logic [127:0] ctr_t;

  localparam word_t MUL_LANE0  = 32'hD2511F53;
  localparam word_t MUL_LANE2  = 32'hCD9E8D57;
  localparam word_t KEY_STEP_0 = 32'h9E3779B9;
  localparam word_t KEY_STEP_1 = 32'hBB67AE85;

  // one mixing round on a 4-word block
  function automatic ctr_t mix_round(ctr_t c, key_t k);
    logic [63:0] pa, pb;
    ctr_t r;
    pa = 64'(c[31:0])  * 64'(MUL_LANE0);
    pb = 64'(c[95:64]) * 64'(MUL_LANE2);
    r[31:0]   = pb[63:32] ^ c[63:32]   ^ k[31:0];
    r[63:32]  = pb[31:0];
    r[95:64]  = pa[63:32] ^ c[127:96]  ^ k[63:32];
    r[127:96] = pa[31:0];
    return r;
  endfunction

  function automatic key_t key_bump(key_t k);
    return {k[63:32] + KEY_STEP_1, k[31:0] + KEY_STEP_0};
  endfunction
endpackage

// File: rtl/crng_ctr_step.sv
module crng_ctr_step
  import crng_pkg::*;
#(
  parameter int HALF_W = 64
) (
  input  logic [2*HALF_W-1:0] ctr_cur,
  input  logic [HALF_W-1:0]   skip_amt,
  input  logic                use_skip,
  output logic [2*HALF_W-1:0] ctr_next
);
  localparam int FULL_W = 2 * HALF_W;

  logic [HALF_W-1:0] addend;
  logic [HALF_W:0]   low_sum;
  logic [HALF_W-1:0] high_sum;

  // one adder serves both the +1 step and the skip
  always_comb begin
    addend   = use_skip ? skip_amt : HALF_W'(1);
    low_sum  = {1'b0, ctr_cur[HALF_W-1:0]} + {1'b0, addend};
    high_sum = ctr_cur[FULL_W-1:HALF_W] + HALF_W'(low_sum[HALF_W]);
    ctr_next = {high_sum, low_sum[HALF_W-1:0]};
  end
endmodule

// File: rtl/crng_bijection.sv
module crng_bijection
  import crng_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  ctr_t ctr_in,
  input  key_t key_in,
  output logic busy,
  output logic done,
  output ctr_t blk_out
);
  localparam int CW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

  ctr_t          st_q;
  key_t          key_q;
  logic [CW-1:0] rnd_q;
  logic          busy_q;
  ctr_t          mixed;

  assign mixed   = mix_round(st_q, key_q);
  assign busy    = busy_q;
  assign done    = busy_q && (rnd_q == LAST);
  assign blk_out = mixed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      key_q  <= '0;
      rnd_q  <= '0;
      busy_q <= 1'b0;
    end else if (abort) begin
      busy_q <= 1'b0;
    end else if (start) begin
      st_q   <= ctr_in;
      key_q  <= key_in;
      rnd_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      st_q  <= mixed;
      key_q <= key_bump(key_q);
      rnd_q <= rnd_q + 1'b1;
      if (done) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/crng_stream.sv
module crng_stream
  import crng_pkg::*;
#(
  parameter int          ROUNDS         = 10,
  parameter logic [63:0] DEFAULT_SEED   = 64'd67280421310721,
  parameter logic [63:0] DEFAULT_SUBSEQ = 64'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed_load,
  input  logic [63:0] seed_val,
  input  logic [63:0] subseq_val,
  input  logic        skip_en,
  input  logic [63:0] skip_count,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_word
);
  localparam int LANES = 4;
  localparam int IW    = $clog2(LANES);

  key_t          key_q;
  ctr_t          ctr_q;
  ctr_t          ctr_nxt;
  logic [IW-1:0] idx_q;
  logic          have_buf_q;
  logic          fill_pend_q;
  word_t         wbuf_q [LANES];
  word_t         blk_w  [LANES];
  ctr_t          blk;
  logic          core_busy, core_done;
  logic          skip_take, fill_start, take;

  assign skip_take  = skip_en && !fill_pend_q && !seed_load;
  assign fill_start = out_ready && !have_buf_q && !fill_pend_q && !seed_load && !skip_take;
  assign out_valid  = have_buf_q;
  assign out_word   = wbuf_q[idx_q];
  assign take       = have_buf_q && out_ready && !seed_load;

  crng_ctr_step #(.HALF_W(64)) u_step (
    .ctr_cur  (ctr_q),
    .skip_amt (skip_count),
    .use_skip (skip_take),
    .ctr_next (ctr_nxt)
  );

  crng_bijection #(.ROUNDS(ROUNDS)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (fill_start),
    .abort   (seed_load),
    .ctr_in  (ctr_q),
    .key_in  (key_q),
    .busy    (core_busy),
    .done    (core_done),
    .blk_out (blk)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign blk_w[g] = blk[32*g +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q       <= DEFAULT_SEED;
      ctr_q       <= {DEFAULT_SUBSEQ, 64'd0};
      idx_q       <= '0;
      have_buf_q  <= 1'b0;
      fill_pend_q <= 1'b0;
      for (int i = 0; i < LANES; i++) wbuf_q[i] <= '0;
    end else if (seed_load) begin
      key_q       <= seed_val;
      ctr_q       <= {subseq_val, 64'd0};
      idx_q       <= '0;
      have_buf_q  <= 1'b0;
      fill_pend_q <= 1'b0;
    end else begin
      if (skip_take || fill_start) ctr_q <= ctr_nxt;
      if (fill_start) fill_pend_q <= 1'b1;
      if (core_done && fill_pend_q) begin
        fill_pend_q <= 1'b0;
        have_buf_q  <= 1'b1;
        for (int i = 0; i < LANES; i++) wbuf_q[i] <= blk_w[i];
      end
      if (take) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == IW'(LANES - 1)) have_buf_q <= 1'b0;
      end
    end
  end

  logic unused_busy;
  assign unused_busy = core_busy;
endmodule

// File: rtl/crng_stream_chk.sv
module crng_stream_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         seed_load,
  input logic         skip_en,
  input logic [63:0]  skip_count,
  input logic         out_valid,
  input logic         out_ready,
  input logic [31:0]  out_word,
  input logic [127:0] ctr_q,
  input logic [1:0]   idx_q,
  input logic         fill_pend_q,
  input logic         fill_start,
  input logic         have_buf_q
);
  AST_NO_VALID_WHILE_FILLING: assert property (@(posedge clk) disable iff (!rst_n)
    fill_pend_q |-> !out_valid); // R10
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !seed_load) |=> (out_valid && $stable(out_word))); // R10
  AST_SEED_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (!out_valid && idx_q == 2'd0 && !fill_pend_q)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |=> (ctr_q == $past(ctr_q) + 128'd1)); // R5
  AST_SKIP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_en && !fill_pend_q && !seed_load) |=> (ctr_q[63:0] == $past(ctr_q[63:0]) + $past(skip_count))); // R8
  AST_PEND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_pend_q && !seed_load) |=> $stable(ctr_q)); // R9
  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !seed_load) |=> (idx_q == $past(idx_q) + 2'd1)); // R6
  AST_EMPTY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !have_buf_q |-> (idx_q == 2'd0)); // R6
endmodule

bind crng_stream crng_stream_chk u_chk (
  .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .skip_en(skip_en),
  .skip_count(skip_count), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .ctr_q(ctr_q), .idx_q(idx_q), .fill_pend_q(fill_pend_q),
  .fill_start(fill_start), .have_buf_q(have_buf_q)
);

// File: tb/crng_stream_tb.sv
module crng_stream_tb;
  localparam int ROUNDS = 10;
  localparam logic [63:0] DEF_SEED = 64'd67280421310721;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seed_load = 1'b0;
  logic [63:0] seed_val = '0, subseq_val = '0;
  logic skip_en = 1'b0;
  logic [63:0] skip_count = '0;
  logic out_valid, out_ready;
  logic [31:0] out_word;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;
  string cur_req = "R6";
  logic [31:0] expq[$];

  // reference state
  logic [63:0]  m_key;
  logic [127:0] m_ctr;
  logic [127:0] m_blk;
  int           m_idx;

  always #4 clk = ~clk;

  crng_stream #(.ROUNDS(ROUNDS)) u_dut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
    .subseq_val(subseq_val), .skip_en(skip_en), .skip_count(skip_count),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
  );

  function automatic logic [127:0] ref_round(logic [127:0] c, logic [63:0] k);
    logic [63:0] a, b;
    a = {32'd0, c[31:0]} * 64'hD2511F53;
    b = {32'd0, c[95:64]} * 64'hCD9E8D57;
    return {a[31:0], a[63:32] ^ c[127:96] ^ k[63:32], b[31:0], b[63:32] ^ c[63:32] ^ k[31:0]};
  endfunction

  function automatic logic [127:0] ref_block(logic [127:0] c, logic [63:0] k);
    for (int r = 0; r < ROUNDS; r++) begin
      c = ref_round(c, k);
      k = {k[63:32] + 32'hBB67AE85, k[31:0] + 32'h9E3779B9};
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_seed(input logic [63:0] s, input logic [63:0] sub);
    m_key = s;
    m_ctr = {sub, 64'd0};
    m_idx = 0;
  endtask

  task automatic m_push();
    if (m_idx == 0) begin
      m_blk = ref_block(m_ctr, m_key);
      m_ctr = m_ctr + 128'd1;
    end
    expq.push_back(m_blk[32*m_idx +: 32]);
    m_idx = (m_idx + 1) % 4;
  endtask

  task automatic m_skip(input logic [63:0] n);
    logic [64:0] s;
    s = {1'b0, m_ctr[63:0]} + {1'b0, n};
    m_ctr = {m_ctr[127:64] + {63'd0, s[64]}, s[63:0]};
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drain(input bit bp);
    int k = 0;
    while (expq.size() > 0) begin
      out_ready = bp ? (k % 3 != 1) : 1'b1;
      k++;
      tick();
    end
    out_ready = 1'b0;
  endtask

  task automatic fetch(input int n, input bit bp, input string req);
    cur_req = req;
    for (int i = 0; i < n; i++) m_push();
    drain(bp);
  endtask

  task automatic do_seed(input logic [63:0] s, input logic [63:0] sub);
    seed_val = s; subseq_val = sub; seed_load = 1'b1;
    tick();
    seed_load = 1'b0;
    m_seed(s, sub);
  endtask

  task automatic do_skip(input logic [63:0] n);
    skip_count = n; skip_en = 1'b1;
    tick();
    skip_en = 1'b0;
    m_skip(n);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) chk(1'b0, "R6 unexpected word", {32'd0, out_word}, 64'd0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(out_word == e, cur_req, {32'd0, out_word}, {32'd0, e});
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    logic [31:0] held;
    out_ready = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    m_seed(DEF_SEED, 64'd0);
    tick();
    @(negedge clk);
    chk(out_valid == 1'b0, "R4 valid low after reset", {63'd0, out_valid}, 64'd0);
    tick();

    // R4 R5 R6 R11: default key, two blocks
    fetch(8, 0, "R4 R5 R11 default stream");

    // R1 R2: loaded seed and subsequence, with back-pressure
    do_seed(64'h0123_4567_89AB_CDEF, 64'h1111_2222_3333_4444);
    fetch(6, 1, "R1 R2 R6 loaded stream");

    // R3: reload mid-block (index 2)
    do_seed(64'hFEDC_BA98_7654_3210, 64'h0000_0005_0000_0009);
    fetch(4, 0, "R3 reload discards buffer");

    // R7: counter all ones wraps to zero
    do_seed(64'hA5A5_5A5A_0F0F_F0F0, 64'hFFFF_FFFF_FFFF_FFFF);
    do_skip(64'hFFFF_FFFF_FFFF_FFFF);
    fetch(4, 0, "R8 skip to top");
    fetch(4, 0, "R7 full wrap to zero");

    // R8: skip with carry into subsequence
    do_skip(64'hFFFF_FFFF_FFFF_FFFF);
    fetch(4, 1, "R8 skip carry into subsequence");

    // R8: skip mid-block only affects later blocks
    fetch(2, 0, "R6 partial");
    do_skip(64'd3);
    fetch(6, 0, "R8 skip mid-block");

    // R9: skip during refill ignored; R10 valid low while pending
    cur_req = "R9 skip ignored while pending";
    for (int i = 0; i < 4; i++) m_push();
    out_ready = 1'b1;
    tick();
    tick();
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid low while pending", {63'd0, out_valid}, 64'd0);
    skip_count = 64'd1000; skip_en = 1'b1;
    tick();
    skip_en = 1'b0;
    drain(0);
    fetch(4, 0, "R9 counter unaffected by ignored skip");

    // R9: skip and request in the same cycle, skip first
    cur_req = "R9 skip precedes refill";
    m_skip(64'd77);
    for (int i = 0; i < 4; i++) m_push();
    skip_count = 64'd77; skip_en = 1'b1; out_ready = 1'b1;
    tick();
    skip_en = 1'b0;
    drain(0);

    // R10: hold under back-pressure
    cur_req = "R10 held word";
    for (int i = 0; i < 4; i++) m_push();
    out_ready = 1'b1;
    tick();
    out_ready = 1'b0;
    repeat (ROUNDS + 4) tick();
    @(negedge clk);
    chk(out_valid == 1'b1, "R10 valid after refill", {63'd0, out_valid}, 64'd1);
    held = out_word;
    chk(held == expq[0], "R10 offered word", {32'd0, held}, {32'd0, expq[0]});
    repeat (3) tick();
    @(negedge clk);
    chk(out_valid == 1'b1 && out_word == held, "R10 word stable under stall", {32'd0, out_word}, {32'd0, held});
    tick();
    drain(0);

    // R3: reload while refill pending
    cur_req = "R3 reload aborts refill";
    out_ready = 1'b1;
    tick();
    out_ready = 1'b0;
    tick();
    do_seed(64'h1357_9BDF_2468_ACE0, 64'd42);
    @(negedge clk);
    chk(out_valid == 1'b0, "R3 empty after reload", {63'd0, out_valid}, 64'd0);
    tick();
    fetch(4, 0, "R3 R1 R2 stream after abort");

    repeat (3) tick();
    chk(expq.size() == 0, "R6 all expected words seen", 64'(expq.size()), 64'd0);
    finish_run();
  end
endmodule